// File: doc/BRIEF.md
# DDR Write-to-Read Turnaround Gate

This block sits in the command path of a DDR SDRAM controller, between the scheduler that picks commands and the register that drives them onto the command bus. It follows every WRITE burst it lets through and decides when a later READ may be released. The WRITE-to-READ spacing is counted from the first rising clock edge after the burst's final data-in pair, not from the WRITE itself. The spacing is waived when the READ selects a different device from the one the last WRITE went to.

A request arrives each cycle as a two-bit command code plus device select, bank, column and auto-precharge bit. Accepted commands appear one cycle later on registered outputs. A READ that would break the turnaround rule is refused in the same cycle through the `stall` output. The scheduler keeps the READ on its inputs, the block drives a NOP in its place, and the READ is released in the first legal cycle. The block also marks the cycles that carry write data pairs. It raises a read-data window after the CAS latency so the capture logic knows when returning data is due.

Top module: `ddr_wtr_gate`

## Requirements
- R1: After reset `cmd_valid`, `stall`, `wr_data_phase` and `rd_data_valid` are low and `cmd_code` reads NOP. With no WRITE since reset, a READ request is not stalled.
- R2: A WRITE requested in cycle c appears on the outputs in cycle c+1. `wr_data_phase` is then high for exactly BURST_LEN/2 cycles, starting the cycle after the WRITE appears.
- R3: A READ to the same device as the last WRITE never appears on the outputs earlier than 1 + BURST_LEN/2 + TWTR_CYC cycles after that WRITE. While it is refused, `stall` is high and `cmd_valid` is low the next cycle. If the READ is held, it appears exactly at that earliest cycle.
- R4: A READ whose device select differs from that of the last WRITE is never stalled. It appears on the outputs the cycle after it is requested, even during the WRITE's data phase.
- R5: `rd_data_valid` rises exactly CAS_LAT cycles after a READ appears on the outputs and stays high for BURST_LEN/2 cycles.
- R6: A WRITE is never stalled. A WRITE accepted while a previous turnaround is still running restarts the burst tracking. A following same-device READ is then timed from the new burst's last data pair.
- R7: Command codes are 2'b00 NOP, 2'b01 WRITE, 2'b10 READ. The code 2'b11 is treated as NOP: it issues nothing, raises no stall and starts no data phase.
- R8: An issued command carries the requested device, bank, column and auto-precharge bit unchanged to `cmd_dev`, `cmd_bank`, `cmd_col` and `cmd_ap`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_cmd | input | 2 | Requested command code (NOP/WRITE/READ) |
| req_dev | input | DEV_W | Requested device select |
| req_bank | input | BANK_W | Requested bank |
| req_col | input | COL_W | Requested starting column |
| req_ap | input | 1 | Auto-precharge bit of the request |
| cmd_valid | output | 1 | A WRITE or READ is driven this cycle |
| cmd_code | output | 2 | Driven command code, NOP when idle |
| cmd_dev | output | DEV_W | Device select of the driven command |
| cmd_bank | output | BANK_W | Bank of the driven command |
| cmd_col | output | COL_W | Column of the driven command |
| cmd_ap | output | 1 | Auto-precharge bit of the driven command |
| stall | output | 1 | The current READ request is refused this cycle |
| wr_data_phase | output | 1 | A write data pair is on the data bus this cycle |
| rd_data_valid | output | 1 | Read data is expected this cycle |

## Verification
The bench builds the gate with TWTR_CYC = 2 and CAS_LAT = 3 instead of the defaults of 1 and 2, with BURST_LEN = 4 and a one-bit device select. With a turnaround of two cycles, an off-by-one in the burst count, the reference edge or the countdown shifts the release cycle of a held READ, so it becomes visible. A CAS latency of three exercises the multi-stage shift-register variant of the read window, and a latency error cannot be confused with the burst length. The single device bit allows a same-device and a cross-device READ against the same WRITE.

// File: rtl/wtr_gate_pkg.sv
package wtr_gate_pkg;

   // Command codes on the request and command ports
   typedef enum logic [1:0] {
      CMD_NOP   = 2'b00,
      CMD_WRITE = 2'b01,
      CMD_READ  = 2'b10,
      CMD_RSVD  = 2'b11
   } ddr_cmd_e;

endpackage

// File: rtl/wtr_burst_track.sv
// Follows one write burst: one cycle for the command, then PAIRS data-pair cycles.
module wtr_burst_track #(
   parameter int PAIRS = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,      // WRITE accepted at this edge
   output logic busy,       // command or data cycles still running
   output logic phase,      // a data pair is on the bus this cycle
   output logic last_pair   // final data pair of the burst is this cycle
);

   localparam int CW = $clog2(PAIRS + 2);
   localparam logic [CW-1:0] LOADV = CW'(PAIRS + 1);
   localparam logic [CW-1:0] PAIRV = CW'(PAIRS);

   logic [CW-1:0] left_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         left_q <= '0;
      end else if (start) begin
         left_q <= LOADV;
      end else if (left_q != '0) begin
         left_q <= left_q - 1'b1;
      end
   end

   assign busy      = (left_q != '0);
   assign phase     = busy && (left_q <= PAIRV);
   assign last_pair = (left_q == CW'(1));

   // R2: the cycle the WRITE is driven carries no data pair yet
   p_gap_before_data_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      start |=> !phase);

endmodule

// File: rtl/wtr_turn_timer.sv
// Turnaround countdown, loaded at the first edge after the last data pair.
module wtr_turn_timer #(
   parameter int TWTR_CYC = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,   // new WRITE: drop any running countdown
   input  logic load,    // edge following the last data pair
   output logic busy
);

   localparam int TW = (TWTR_CYC > 1) ? $clog2(TWTR_CYC) : 1;
   localparam logic [TW-1:0] LOADV = TW'(TWTR_CYC - 1);

   logic [TW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clear) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= LOADV;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign busy = (cnt_q != '0);

   // R6: a restart leaves no countdown running in the next cycle
   p_clear_drops_timer_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> !busy);

endmodule

// File: rtl/wtr_rd_window.sv
// Read data window: opens CAS_LAT cycles after a driven READ, lasts PAIRS cycles.
module wtr_rd_window #(
   parameter int CAS_LAT = 2,
   parameter int PAIRS   = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rd_go,     // READ driven this cycle
   output logic rd_valid
);

   localparam int CW = $clog2(PAIRS + 1);
   localparam int AW = $clog2(CAS_LAT + PAIRS + 1);
   localparam logic [AW-1:0] AMAX = AW'(CAS_LAT + PAIRS);

   logic          tap;      // high one cycle before the window opens
   logic [CW-1:0] win_q;

   generate
      if (CAS_LAT == 1) begin : g_lat1
         assign tap = rd_go;
      end else if (CAS_LAT == 2) begin : g_lat2
         logic stage_q;
         always_ff @(posedge clk) begin
            if (!rst_n) stage_q <= 1'b0;
            else        stage_q <= rd_go;
         end
         assign tap = stage_q;
      end else begin : g_latn
         logic [CAS_LAT-2:0] pipe_q;
         always_ff @(posedge clk) begin
            if (!rst_n) pipe_q <= '0;
            else        pipe_q <= {pipe_q[CAS_LAT-3:0], rd_go};
         end
         assign tap = pipe_q[CAS_LAT-2];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         win_q <= '0;
      end else if (tap) begin
         win_q <= CW'(PAIRS);
      end else if (win_q != '0) begin
         win_q <= win_q - 1'b1;
      end
   end

   assign rd_valid = (win_q != '0);

   // Checker-side age of the newest READ, saturating
   logic [AW-1:0] age_q;
   always_ff @(posedge clk) begin
      if (!rst_n)              age_q <= AMAX;
      else if (rd_go)          age_q <= AW'(1);
      else if (age_q != AMAX)  age_q <= age_q + 1'b1;
   end

   // R5: the window closes once the newest READ's burst has been returned
   p_rd_window_closes_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      (age_q == AMAX) |-> !rd_valid);

endmodule

// File: rtl/ddr_wtr_gate.sv
module ddr_wtr_gate
   import wtr_gate_pkg::*;
#(
   parameter int DEV_W     = 1,
   parameter int BANK_W    = 2,
   parameter int COL_W     = 10,
   parameter int BURST_LEN = 4,
   parameter int TWTR_CYC  = 1,
   parameter int CAS_LAT   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        req_cmd,
   input  logic [DEV_W-1:0]  req_dev,
   input  logic [BANK_W-1:0] req_bank,
   input  logic [COL_W-1:0]  req_col,
   input  logic              req_ap,
   output logic              cmd_valid,
   output logic [1:0]        cmd_code,
   output logic [DEV_W-1:0]  cmd_dev,
   output logic [BANK_W-1:0] cmd_bank,
   output logic [COL_W-1:0]  cmd_col,
   output logic              cmd_ap,
   output logic              stall,
   output logic              wr_data_phase,
   output logic              rd_data_valid
);

   localparam int PAIRS = BURST_LEN / 2;

   generate
      if (BURST_LEN < 2 || (BURST_LEN % 2) != 0) begin : g_bad_burst
         $error("BURST_LEN must be an even value of at least 2");
      end
      if (TWTR_CYC < 1) begin : g_bad_twtr
         $error("TWTR_CYC must be at least 1");
      end
      if (CAS_LAT < 1) begin : g_bad_cl
         $error("CAS_LAT must be at least 1");
      end
      if (DEV_W < 1 || BANK_W < 1 || COL_W < 1) begin : g_bad_width
         $error("address field widths must be at least 1");
      end
   endgenerate

   logic             wr_req, rd_req, wr_accept, rd_accept;
   logic             trk_busy, trk_last, tmr_busy, gate_busy;
   logic [DEV_W-1:0] last_wr_dev_q;

   assign wr_req    = (req_cmd == CMD_WRITE);
   assign rd_req    = (req_cmd == CMD_READ);
   assign gate_busy = trk_busy || tmr_busy;
   assign stall     = rd_req && (req_dev == last_wr_dev_q) && gate_busy;
   assign wr_accept = wr_req;
   assign rd_accept = rd_req && !stall;

   wtr_burst_track #(.PAIRS(PAIRS)) u_track (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (wr_accept),
      .busy      (trk_busy),
      .phase     (wr_data_phase),
      .last_pair (trk_last)
   );

   wtr_turn_timer #(.TWTR_CYC(TWTR_CYC)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (wr_accept),
      .load  (trk_last && !wr_accept),
      .busy  (tmr_busy)
   );

   wtr_rd_window #(.CAS_LAT(CAS_LAT), .PAIRS(PAIRS)) u_rdwin (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_go    (cmd_valid && (cmd_code == CMD_READ)),
      .rd_valid (rd_data_valid)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmd_valid     <= 1'b0;
         cmd_code      <= CMD_NOP;
         cmd_dev       <= '0;
         cmd_bank      <= '0;
         cmd_col       <= '0;
         cmd_ap        <= 1'b0;
         last_wr_dev_q <= '0;
      end else begin
         cmd_valid <= wr_accept || rd_accept;
         if (wr_accept)      cmd_code <= CMD_WRITE;
         else if (rd_accept) cmd_code <= CMD_READ;
         else                cmd_code <= CMD_NOP;
         if (wr_accept || rd_accept) begin
            cmd_dev  <= req_dev;
            cmd_bank <= req_bank;
            cmd_col  <= req_col;
            cmd_ap   <= req_ap;
         end
         if (wr_accept) last_wr_dev_q <= req_dev;
      end
   end

   // R3: only READ requests are ever refused
   p_stall_read_only_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      stall |-> (req_cmd == CMD_READ));

   // R3: a refused cycle drives a NOP
   p_stall_blocks_issue_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      stall |=> !cmd_valid);

   // R3: no same-device READ overlaps write data
   p_no_read_in_phase_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_code == CMD_READ && cmd_dev == last_wr_dev_q) |-> !wr_data_phase);

   // R2: data pairs follow a driven WRITE
   p_wr_phase_follows_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_code == CMD_WRITE) |=> wr_data_phase);

   // R6: a WRITE request is always driven on the next cycle
   p_write_never_stalls_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      (req_cmd == CMD_WRITE) |=> (cmd_valid && cmd_code == CMD_WRITE));

endmodule

// File: tb/test_ddr_wtr_gate.sv
module test_ddr_wtr_gate;

   localparam int BL = 4;
   localparam int TW = 2;
   localparam int CL = 3;
   localparam int PR = BL / 2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] req_cmd = 2'b00;
   logic       req_dev = 1'b0;
   logic [1:0] req_bank = '0;
   logic [9:0] req_col = '0;
   logic       req_ap = 1'b0;
   logic       cmd_valid, cmd_ap, stall, wr_data_phase, rd_data_valid, cmd_dev;
   logic [1:0] cmd_code, cmd_bank;
   logic [9:0] cmd_col;

   int cyc = 0;
   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   ddr_wtr_gate #(
      .DEV_W(1), .BANK_W(2), .COL_W(10),
      .BURST_LEN(BL), .TWTR_CYC(TW), .CAS_LAT(CL)
   ) i_ddr_wtr_gate (
      .clk(clk), .rst_n(rst_n),
      .req_cmd(req_cmd), .req_dev(req_dev), .req_bank(req_bank),
      .req_col(req_col), .req_ap(req_ap),
      .cmd_valid(cmd_valid), .cmd_code(cmd_code), .cmd_dev(cmd_dev),
      .cmd_bank(cmd_bank), .cmd_col(cmd_col), .cmd_ap(cmd_ap),
      .stall(stall), .wr_data_phase(wr_data_phase), .rd_data_valid(rd_data_valid)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic set_req(input logic [1:0] c, input logic d, input logic [1:0] b,
                          input logic [9:0] col, input logic ap);
      req_cmd = c; req_dev = d; req_bank = b; req_col = col; req_ap = ap;
   endtask

   task automatic idle(input int n);
      set_req(2'b00, 1'b0, 2'b00, 10'h0, 1'b0);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   // Request a WRITE; returns the cycle in which it is driven
   task automatic issue_write(input logic d, input logic [1:0] b, input logic [9:0] col,
                              input logic ap, output int wcyc);
      set_req(2'b01, d, b, col, ap);
      #1;
      chk("R6", "stall on WRITE request", int'(stall), 0);
      @(negedge clk);
      wcyc = cyc;
      chk("R2", "WRITE driven", int'(cmd_valid && cmd_code == 2'b01), 1);
      chk("R8", "WRITE fields", int'({cmd_dev, cmd_bank, cmd_col, cmd_ap}),
          int'({d, b, col, ap}));
      set_req(2'b00, 1'b0, 2'b00, 10'h0, 1'b0);
   endtask

   // Hold a READ until released; returns driven cycle and stalled cycles
   task automatic hold_read(input logic d, input logic [1:0] b, input logic [9:0] col,
                            input int wcyc, output int rcyc, output int nstall);
      nstall = 0;
      for (int k = 0; k < 40; k++) begin
         set_req(2'b10, d, b, col, 1'b0);
         #1;
         chk("R2", "wr_data_phase", int'(wr_data_phase),
             int'((cyc - wcyc) >= 1 && (cyc - wcyc) <= PR));
         if (nstall > 0) chk("R3", "NOP while stalled", int'(cmd_valid), 0);
         if (!stall) break;
         nstall++;
         @(negedge clk);
      end
      @(negedge clk);
      rcyc = cyc;
      chk("R3", "READ driven", int'(cmd_valid && cmd_code == 2'b10), 1);
      chk("R8", "READ fields", int'({cmd_dev, cmd_bank, cmd_col}), int'({d, b, col}));
      set_req(2'b00, 1'b0, 2'b00, 10'h0, 1'b0);
   endtask

   task automatic t_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "cmd_valid after reset", int'(cmd_valid), 0);
      chk("R1", "cmd_code after reset", int'(cmd_code), 0);
      chk("R1", "stall after reset", int'(stall), 0);
      chk("R1", "wr_data_phase after reset", int'(wr_data_phase), 0);
      chk("R1", "rd_data_valid after reset", int'(rd_data_valid), 0);
      set_req(2'b10, 1'b0, 2'b00, 10'h5, 1'b0);
      #1;
      chk("R1", "READ with no prior WRITE stalled", int'(stall), 0);
      @(negedge clk);
      chk("R1", "READ with no prior WRITE driven", int'(cmd_valid && cmd_code == 2'b10), 1);
      idle(CL + PR + 2);
   endtask

   task automatic t_same_dev();
      int w, r, ns;
      issue_write(1'b0, 2'd1, 10'h010, 1'b0, w);
      hold_read(1'b0, 2'd1, 10'h020, w, r, ns);
      chk("R3", "WRITE-to-READ spacing", r - w, 1 + PR + TW);
      chk("R3", "stalled cycles", ns, PR + TW);
      chk("R2", "phase after READ", int'(wr_data_phase), 0);
      idle(CL + PR + 2);
   endtask

   task automatic t_other_dev();
      int w;
      issue_write(1'b0, 2'd2, 10'h030, 1'b1, w);
      set_req(2'b10, 1'b1, 2'd3, 10'h040, 1'b0);
      #1;
      chk("R4", "stall for other device", int'(stall), 0);
      @(negedge clk);
      chk("R4", "READ cycle for other device", cyc - w, 1);
      chk("R4", "READ driven for other device", int'(cmd_valid && cmd_code == 2'b10), 1);
      chk("R4", "READ device", int'(cmd_dev), 1);
      chk("R4", "READ overlaps write data", int'(wr_data_phase), 1);
      idle(CL + PR + 4);
   endtask

   task automatic t_rd_latency();
      int r;
      set_req(2'b10, 1'b1, 2'd0, 10'h050, 1'b0);
      @(negedge clk);
      r = cyc;
      chk("R5", "rd_data_valid in READ cycle", int'(rd_data_valid), 0);
      set_req(2'b00, 1'b0, 2'b00, 10'h0, 1'b0);
      for (int k = 1; k <= CL + PR; k++) begin
         @(negedge clk);
         chk("R5", $sformatf("rd_data_valid at READ+%0d", k), int'(rd_data_valid),
             int'(k >= CL && k < CL + PR));
      end
      chk("R5", "cycle count", cyc - r, CL + PR);
      idle(3);
   endtask

   task automatic t_restart();
      int w1, w2, r, ns;
      issue_write(1'b0, 2'd0, 10'h060, 1'b0, w1);
      idle(PR + 1);
      issue_write(1'b0, 2'd0, 10'h070, 1'b0, w2);
      chk("R6", "second WRITE not delayed", w2 - w1, PR + 2);
      hold_read(1'b0, 2'd0, 10'h080, w2, r, ns);
      chk("R6", "READ timed from new burst", r - w2, 1 + PR + TW);
      idle(CL + PR + 2);
   endtask

   task automatic t_reserved();
      set_req(2'b11, 1'b0, 2'd1, 10'h090, 1'b1);
      #1;
      chk("R7", "stall on reserved code", int'(stall), 0);
      @(negedge clk);
      chk("R7", "reserved code drives command", int'(cmd_valid), 0);
      chk("R7", "reserved code output", int'(cmd_code), 0);
      set_req(2'b00, 1'b0, 2'b00, 10'h0, 1'b0);
      @(negedge clk);
      chk("R7", "reserved code starts data phase", int'(wr_data_phase), 0);
      chk("R7", "NOP drives command", int'(cmd_valid), 0);
   endtask

   initial begin
      t_reset();
      t_same_dev();
      t_other_dev();
      t_rd_latency();
      t_restart();
      t_reserved();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(20000 * 5);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL R1 watchdog: actual running expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule